// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives the processor reset and the watchdog alarm of a supervisory circuit. Its inputs are already digital: a low-supply flag that is synchronous to the block clock, an asynchronous active-low push-button input, a one-cycle kick pulse from the bus logic that detects host activity, and two 2-bit codes. One code selects the hold time that follows a reset cause. The other selects the watchdog period, and one value of that code turns the watchdog off.

All times are given in milliseconds and counted against a millisecond tick divided down from the clock. The parameter `TICKS_PER_MS` sets how many clock cycles make up one millisecond, so simulation can run with a small value. Each timer has its own divider, and that divider is cleared whenever its timer restarts. As a result every delay is an exact number of cycles: the number of milliseconds times `TICKS_PER_MS`. Two one-cycle strobes report a watchdog expiry and a newly accepted manual reset to outside fault-logging logic.

Top module: `sup_reset_wdog`

## Requirements
- R1: After the last reset cause goes away, reset stays asserted for exactly `D*TICKS_PER_MS` clock cycles, where D in ms comes from `pup_code_i`: 2'b00=50, 2'b01=200, 2'b10=400, 2'b11=800. The same rule sets the power-on hold that follows release of `rst_ni`.
- R2: When `supply_low_i` is sampled high, reset is asserted from the next cycle on and stays asserted while the flag is high.
- R3: `mr_n_i` passes through a two-flop synchroniser and a filter. A change of level is accepted only after the synchronised level has differed from the accepted level for `DEBOUNCE_MS*TICKS_PER_MS` consecutive cycles, so shorter low pulses have no effect on reset.
- R4: An accepted manual reset asserts reset one cycle after acceptance. Reset is held while the button stays low and, once the release has also been filtered, for the R1 delay afterwards.
- R5: `rst_o` is always the complement of `rst_n_o`.
- R6: If no kick arrives, `wdo_n_o` goes low exactly `P*TICKS_PER_MS` cycles after the kick-sampling edge, where P in ms comes from `wdt_code_i`: 2'b00=1400, 2'b01=200, 2'b10=25.
- R7: With `wdt_code_i`=2'b11 the watchdog is off: `wdo_n_o` stays high, no expiry strobe is raised, and the counter is held at zero.
- R8: A kick restarts the period count from zero. A kick sampled on the same edge as the expiry wins, so no alarm is raised on that edge.
- R9: Once low, `wdo_n_o` stays low for exactly `W*TICKS_PER_MS` cycles, with W=200 ms for codes 2'b00 and 2'b01 and W=25 ms for code 2'b10. Kicks during this pulse are ignored. A fresh period starts when the pulse ends.
- R10: While reset is asserted the watchdog is held cleared and `wdo_n_o` is high from the following cycle on. After reset is released, the period is counted from zero.
- R11: `wdt_evt_o` is high for one cycle, in the first cycle that `wdo_n_o` is low. `mr_evt_o` is high for one cycle when a manual reset is accepted; an accepted release raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset (power-on) |
| supply_low_i | input | 1 | Synchronised flag, high while the supply is below its trip point |
| mr_n_i | input | 1 | Asynchronous active-low manual reset input |
| kick_i | input | 1 | One-cycle watchdog restart pulse |
| pup_code_i | input | 2 | Reset hold time select |
| wdt_code_i | input | 2 | Watchdog period select, 2'b11 = off |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| wdo_n_o | output | 1 | Active-low watchdog alarm |
| wdt_evt_o | output | 1 | One-cycle strobe on watchdog expiry |
| mr_evt_o | output | 1 | One-cycle strobe on accepted manual reset |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a kick and the period expiry. The bench times a kick so that it is sampled on exactly the edge where the count would reach its limit, then expects `wdo_n_o` to stay high and the next expiry to come one full period after that edge. The second pair is reset entry and an alarm pulse already in progress. The bench lowers the supply in the middle of an alarm pulse and expects the alarm to clear two cycles later. After the reset hold ends, it expects the watchdog to count a whole period again, measured from the release edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Watchdog period select codes
    typedef enum logic [1:0] {
        WDT_LONG  = 2'b00,
        WDT_MID   = 2'b01,
        WDT_SHORT = 2'b10,
        WDT_OFF   = 2'b11
    } wdt_code_e;

    // Longest millisecond count any timer reaches
    localparam int unsigned MAX_MS = 1400;
    localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

    typedef logic [MS_W-1:0] ms_cnt_t;

    // Reset hold time in milliseconds
    function automatic int unsigned hold_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 50;
            2'b01:   return 200;
            2'b10:   return 400;
            default: return 800;
        endcase
    endfunction

    // Watchdog period in milliseconds (off code returns 0)
    function automatic int unsigned period_ms(input wdt_code_e code);
        case (code)
            WDT_LONG:  return 1400;
            WDT_MID:   return 200;
            WDT_SHORT: return 25;
            default:   return 0;
        endcase
    endfunction

    // Alarm pulse length in milliseconds
    function automatic int unsigned pulse_ms(input wdt_code_e code);
        case (code)
            WDT_SHORT: return 25;
            default:   return 200;
        endcase
    endfunction

endpackage

// File: rtl/sup_ms_tick.sv
// Millisecond divider with synchronous restart.
module sup_ms_tick #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } tick_state_t;

    tick_state_t s_d, s_q;

    // tick depends only on state, never on clr_i, so no loop through users
    assign tick_o = (s_q.pre == LAST);

    always_comb begin
        s_d = s_q;
        if (clr_i || tick_o) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sup_mr_filter.sv
// Two-flop synchroniser plus symmetric debounce filter for the push-button.
module sup_mr_filter #(
    parameter int unsigned DEB_CYCLES = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mr_n_i,
    output logic mr_low_o,
    output logic mr_evt_o
);
    localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          level;   // accepted level, active low like the pin
        logic [CW-1:0] cnt;
        logic          evt;
    } mr_state_t;

    mr_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.sync1 = mr_n_i;
        s_d.sync2 = s_q.sync1;
        s_d.evt   = 1'b0;
        if (s_q.sync2 == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CNT_LAST) begin
            s_d.level = s_q.sync2;
            s_d.cnt   = '0;
            s_d.evt   = ~s_q.sync2;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.sync1 <= 1'b1;
            s_q.sync2 <= 1'b1;
            s_q.level <= 1'b1;
            s_q.cnt   <= '0;
            s_q.evt   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mr_low_o = ~s_q.level;
    assign mr_evt_o = s_q.evt;
endmodule

// File: rtl/sup_rst_ctrl.sv
// Reset hold: asserted while any cause is present, released after the hold time.
module sup_rst_ctrl #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_low_i,
    input  logic       mr_low_i,
    input  logic [1:0] pup_code_i,
    output logic       rst_act_o
);
    import sup_pkg::*;

    typedef struct packed {
        logic    act;
        ms_cnt_t ms;
    } rst_state_t;

    rst_state_t s_d, s_q;
    logic       tick;
    logic       tick_clr;
    logic       cause;
    ms_cnt_t    ms_last;

    assign cause   = supply_low_i | mr_low_i;
    assign ms_last = MS_W'(hold_ms(pup_code_i) - 1);

    sup_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    always_comb begin
        s_d      = s_q;
        tick_clr = 1'b0;
        if (cause) begin
            s_d.act  = 1'b1;
            s_d.ms   = '0;
            tick_clr = 1'b1;
        end else if (s_q.act) begin
            if (tick) begin
                if (s_q.ms >= ms_last) begin
                    s_d.act  = 1'b0;
                    s_d.ms   = '0;
                    tick_clr = 1'b1;
                end else begin
                    s_d.ms = s_q.ms + 1'b1;
                end
            end
        end else begin
            tick_clr = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.act <= 1'b1;
            s_q.ms  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_act_o = s_q.act;
endmodule

// File: rtl/sup_wdog.sv
// Watchdog period counter and fixed-length alarm pulse.
module sup_wdog #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rst_act_i,
    input  logic       kick_i,
    input  logic [1:0] code_i,
    output logic       fire_o,
    output logic       evt_o
);
    import sup_pkg::*;

    typedef struct packed {
        logic    fire;
        logic    evt;
        ms_cnt_t ms;
    } wd_state_t;

    wd_state_t s_d, s_q;
    wdt_code_e code;
    logic      tick;
    logic      tick_clr;
    ms_cnt_t   per_last;
    ms_cnt_t   pulse_last;

    assign code       = wdt_code_e'(code_i);
    assign per_last   = MS_W'(period_ms(code) - 1);
    assign pulse_last = MS_W'(pulse_ms(code) - 1);

    sup_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    // Priority: reset / off, then running pulse, then kick, then expiry.
    always_comb begin
        s_d      = s_q;
        s_d.evt  = 1'b0;
        tick_clr = 1'b0;
        if (rst_act_i || code == WDT_OFF) begin
            s_d.fire = 1'b0;
            s_d.ms   = '0;
            tick_clr = 1'b1;
        end else if (s_q.fire) begin
            if (tick) begin
                if (s_q.ms >= pulse_last) begin
                    s_d.fire = 1'b0;
                    s_d.ms   = '0;
                    tick_clr = 1'b1;
                end else begin
                    s_d.ms = s_q.ms + 1'b1;
                end
            end
        end else if (kick_i) begin
            s_d.ms   = '0;
            tick_clr = 1'b1;
        end else if (tick) begin
            if (s_q.ms >= per_last) begin
                s_d.fire = 1'b1;
                s_d.evt  = 1'b1;
                s_d.ms   = '0;
                tick_clr = 1'b1;
            end else begin
                s_d.ms = s_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fire_o = s_q.fire;
    assign evt_o  = s_q.evt;
endmodule

// File: rtl/sup_reset_wdog.sv
// Supervisor top: manual reset filter, reset hold and watchdog.
module sup_reset_wdog #(
    parameter int unsigned TICKS_PER_MS = 1000,
    parameter int unsigned DEBOUNCE_MS  = 5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_low_i,
    input  logic       mr_n_i,
    input  logic       kick_i,
    input  logic [1:0] pup_code_i,
    input  logic [1:0] wdt_code_i,
    output logic       rst_n_o,
    output logic       rst_o,
    output logic       wdo_n_o,
    output logic       wdt_evt_o,
    output logic       mr_evt_o
);
    localparam int unsigned DEB_CYCLES = DEBOUNCE_MS * TICKS_PER_MS;

    logic mr_low;
    logic rst_act;
    logic wd_fire;

    sup_mr_filter #(.DEB_CYCLES(DEB_CYCLES)) i_mr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mr_n_i   (mr_n_i),
        .mr_low_o (mr_low),
        .mr_evt_o (mr_evt_o)
    );

    sup_rst_ctrl #(.TICKS_PER_MS(TICKS_PER_MS)) i_rst (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .supply_low_i (supply_low_i),
        .mr_low_i     (mr_low),
        .pup_code_i   (pup_code_i),
        .rst_act_o    (rst_act)
    );

    sup_wdog #(.TICKS_PER_MS(TICKS_PER_MS)) i_wd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_act_i (rst_act),
        .kick_i    (kick_i),
        .code_i    (wdt_code_i),
        .fire_o    (wd_fire),
        .evt_o     (wdt_evt_o)
    );

    assign rst_o   = rst_act;
    assign rst_n_o = ~rst_act;
    assign wdo_n_o = ~wd_fire;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       supply_low_i,
    input logic       kick_i,
    input logic [1:0] wdt_code_i,
    input logic       rst_n_o,
    input logic       rst_o,
    input logic       wdo_n_o,
    input logic       wdt_evt_o,
    input logic       mr_evt_o
);
    p_supply_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_low_i |=> !rst_n_o);

    p_polarity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_o == !rst_n_o);

    p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdt_code_i == 2'b11) |=> wdo_n_o);

    p_kick_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_i && wdo_n_o) |=> wdo_n_o);

    p_idle_in_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rst_n_o |=> wdo_n_o);

    p_wdt_evt_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_evt_o |=> !wdt_evt_o);

    p_wdt_evt_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wdo_n_o) |-> wdt_evt_o);

    p_wdt_evt_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_evt_o |-> !wdo_n_o);

    p_mr_evt_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mr_evt_o |=> !mr_evt_o);
endmodule

bind sup_reset_wdog sup_reset_wdog_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_low_i (supply_low_i),
    .kick_i       (kick_i),
    .wdt_code_i   (wdt_code_i),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o),
    .wdo_n_o      (wdo_n_o),
    .wdt_evt_o    (wdt_evt_o),
    .mr_evt_o     (mr_evt_o)
);

// File: tb/test_sup_reset_wdog.sv
module test_sup_reset_wdog;
    localparam int TPM = 2;
    localparam int DEB = 3;
    localparam int DEBC = DEB * TPM;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       supply_low = 1'b0;
    logic       mr_n = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] pup = 2'b01;
    logic [1:0] wdt = 2'b11;
    logic       rst_n_o, rst_o, wdo_n_o, wdt_evt_o, mr_evt_o;

    int checks = 0;
    int errors = 0;
    int mr_evts = 0;
    int wd_evts = 0;

    always #5 clk = ~clk;

    sup_reset_wdog #(.TICKS_PER_MS(TPM), .DEBOUNCE_MS(DEB)) i_sup_reset_wdog (
        .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low), .mr_n_i(mr_n),
        .kick_i(kick), .pup_code_i(pup), .wdt_code_i(wdt),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .wdo_n_o(wdo_n_o),
        .wdt_evt_o(wdt_evt_o), .mr_evt_o(mr_evt_o)
    );

    always @(negedge clk) begin
        if (mr_evt_o) mr_evts++;
        if (wdt_evt_o) wd_evts++;
    end

    function automatic int hold_cyc(input logic [1:0] c);
        case (c)
            2'b00: return 50 * TPM;
            2'b01: return 200 * TPM;
            2'b10: return 400 * TPM;
            default: return 800 * TPM;
        endcase
    endfunction

    function automatic int per_cyc(input logic [1:0] c);
        case (c)
            2'b00: return 1400 * TPM;
            2'b01: return 200 * TPM;
            default: return 25 * TPM;
        endcase
    endfunction

    function automatic int pulse_cyc(input logic [1:0] c);
        return (c == 2'b10) ? 25 * TPM : 200 * TPM;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        cyc(1);
        kick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int L, P, W, e0;
        cyc(3);
        check("R1 reset state rst_n", rst_n_o, 0);
        check("R5 reset state rst", rst_o, 1);
        check("R10 reset state wdo", wdo_n_o, 1);
        check("R11 reset state evts", wdt_evt_o + mr_evt_o, 0);

        // R1 power-on hold
        rst_ni = 1'b1;
        L = hold_cyc(pup);
        cyc(L - 1);
        check("R1 power-on hold", rst_n_o, 0);
        cyc(1);
        check("R1 power-on release", rst_n_o, 1);
        check("R5 polarity", rst_o, 0);

        // R1/R2 sweep of hold codes
        for (int c = 0; c < 4; c++) begin
            pup = 2'(c);
            supply_low = 1'b1;
            cyc(1);
            check("R2 supply low asserts", rst_n_o, 0);
            cyc(5);
            check("R2 held while low", rst_n_o, 0);
            check("R5 polarity in reset", rst_o, 1);
            supply_low = 1'b0;
            L = hold_cyc(pup);
            cyc(L - 1);
            check("R1 hold code", rst_n_o, 0);
            cyc(1);
            check("R1 release code", rst_n_o, 1);
        end

        // R2 single-cycle supply dip
        pup = 2'b00;
        L = hold_cyc(pup);
        supply_low = 1'b1;
        cyc(1);
        supply_low = 1'b0;
        check("R2 dip asserts", rst_n_o, 0);
        cyc(L - 1);
        check("R1 dip hold", rst_n_o, 0);
        cyc(1);
        check("R1 dip release", rst_n_o, 1);

        // R3 short manual pulse ignored
        mr_n = 1'b0;
        cyc(DEBC - 1);
        mr_n = 1'b1;
        cyc(20);
        check("R3 short pulse no reset", rst_n_o, 1);
        check("R3 short pulse no strobe", mr_evts, 0);

        // R4 accepted manual reset
        mr_n = 1'b0;
        cyc(DEBC + 2);
        check("R4 not yet asserted", rst_n_o, 1);
        check("R11 mr strobe", mr_evt_o, 1);
        cyc(1);
        check("R4 manual asserts", rst_n_o, 0);
        check("R11 mr strobe one cycle", mr_evt_o, 0);
        cyc(30);
        check("R4 held while pressed", rst_n_o, 0);
        mr_n = 1'b1;
        cyc(DEBC + 1 + L);
        check("R4 hold after release", rst_n_o, 0);
        cyc(1);
        check("R4 release", rst_n_o, 1);
        check("R11 single mr strobe", mr_evts, 1);

        // R6/R9 period and pulse sweep
        for (int c = 0; c < 3; c++) begin
            wdt = 2'(c);
            P = per_cyc(wdt);
            W = pulse_cyc(wdt);
            do_kick();
            cyc(P - 1);
            check("R6 before expiry", wdo_n_o, 1);
            cyc(1);
            check("R6 expiry", wdo_n_o, 0);
            check("R11 wdt strobe", wdt_evt_o, 1);
            cyc(1);
            check("R11 wdt strobe one cycle", wdt_evt_o, 0);
            cyc(W - 2);
            check("R9 pulse held", wdo_n_o, 0);
            cyc(1);
            check("R9 pulse end", wdo_n_o, 1);
            cyc(P - 1);
            check("R9 fresh period running", wdo_n_o, 1);
            cyc(1);
            check("R9 fresh period expiry", wdo_n_o, 0);
            cyc(W);
            check("R9 second pulse end", wdo_n_o, 1);
        end

        // R8 kick restarts the count
        wdt = 2'b10;
        P = per_cyc(wdt);
        W = pulse_cyc(wdt);
        do_kick();
        cyc(P - 10);
        do_kick();
        cyc(9);
        check("R8 restart passes old expiry", wdo_n_o, 1);
        cyc(P - 10);
        check("R8 before new expiry", wdo_n_o, 1);
        cyc(1);
        check("R8 new expiry", wdo_n_o, 0);
        cyc(W);

        // R8 kick on the expiry edge wins
        do_kick();
        cyc(P - 1);
        e0 = wd_evts;
        do_kick();
        check("R8 same-edge kick wins", wdo_n_o, 1);
        check("R8 no strobe on same edge", wd_evts, e0);
        cyc(P - 1);
        check("R8 period after same-edge kick", wdo_n_o, 1);
        cyc(1);
        check("R8 expiry after same-edge kick", wdo_n_o, 0);

        // R9 kick during pulse ignored
        cyc(10);
        do_kick();
        cyc(W - 12);
        check("R9 kick in pulse ignored", wdo_n_o, 0);
        cyc(1);
        check("R9 pulse length kept", wdo_n_o, 1);

        // R10 reset during pulse, then full period after release
        pup = 2'b00;
        L = hold_cyc(pup);
        do_kick();
        cyc(P);
        check("R10 pre-fire", wdo_n_o, 0);
        cyc(5);
        supply_low = 1'b1;
        cyc(2);
        check("R10 reset clears alarm", wdo_n_o, 1);
        cyc(3);
        supply_low = 1'b0;
        cyc(L + P - 1);
        check("R10 count from release", wdo_n_o, 1);
        cyc(1);
        check("R10 expiry after release", wdo_n_o, 0);
        cyc(W);

        // R7 off code
        wdt = 2'b11;
        cyc(1);
        e0 = wd_evts;
        cyc(3000);
        check("R7 off keeps alarm high", wdo_n_o, 1);
        check("R7 off raises no strobe", wd_evts, e0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule